// File: doc/BRIEF.md
# Low-Power Escape Sequencer for a Serial Data Lane

This block owns the two single-ended low-power line outputs of one serial data lane and uses them to carry escape traffic. When idle it holds the Stop level. A request starts the entry choreography. The block then sends an 8-bit command, one bit at a time, as a mark followed by a space. After the command it either streams payload bytes taken from a valid/ready port and then leaves through the exit choreography, or it parks the lane in the ultra-low-power level.

While parked, the lane stays at Space until the `wake` input is seen. The block then holds Mark-1 for a fixed wake-up interval, given in clock cycles by a parameter, before it returns to Stop. Every other line state lasts a run-time number of clock cycles. That number is captured when the request is accepted. Line levels are written LP-xy, where x is `lp_p` and y is `lp_n`. Mark-0 is LP-01, Mark-1 is LP-10, Space is LP-00 and Stop is LP-11.

Top module: `esc_lane_tx`

## Requirements
- R1: During and after reset, with no request, the lines are at LP-11, `busy` is 0 and `tx_ready` is 0.
- R2: A request taken while idle produces LP-10, LP-00, LP-01, LP-00. Each level lasts H cycles, and the first one appears in the cycle after the request edge.
- R3: Each bit is a mark of H cycles (LP-01 for a 0 bit, LP-10 for a 1 bit) followed by LP-00 for H cycles. The command goes first, and each byte is sent LSB first.
- R4: In the last cycle of a byte's final space, if `tx_valid` is 1, then `tx_ready` is 1 in that same cycle. The accepted `tx_data` byte follows directly, with no gap.
- R5: After a byte, if no payload byte is valid, the lines show LP-10 for H cycles and then return to LP-11.
- R6: A request with `req_ulp`=1 sends the command and then holds LP-00 until `wake` is sampled high. During the whole sequence `tx_ready` stays 0, whatever `tx_valid` does.
- R7: In the parked state, a `wake` sampled at a clock edge gives LP-10 for exactly WAKE_CYC cycles from the next cycle on, followed by LP-11. A `wake` while idle has no effect.
- R8: `busy` is 1 in every cycle from the first entry level until the lines return to LP-11. It is 0 whenever the lines are at LP-11.
- R9: H equals `hold_cycles` as sampled with the request, and a value of 0 counts as 1. Changing `hold_cycles` during a sequence has no effect on that sequence.
- R10: A request raised while `busy` is 1 is ignored, and the sequence in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hold_cycles | input | CNT_W | Cycles per line state, captured with the request |
| req | input | 1 | Start an escape sequence (taken only when idle) |
| req_ulp | input | 1 | 1: park in ultra-low-power after the command |
| req_cmd | input | 8 | Command byte |
| tx_valid | input | 1 | Payload byte available |
| tx_data | input | 8 | Payload byte |
| tx_ready | output | 1 | Payload byte taken at this edge |
| wake | input | 1 | Leave the parked state |
| lp_p | output | 1 | Positive low-power line |
| lp_n | output | 1 | Negative low-power line |
| busy | output | 1 | Sequence in progress |

## Verification
The bench rebuilds the whole line waveform as runs of level and length and compares it with the waveform expected from the requirements. This catches a design that reverses the bit order, swaps the two marks, drops a space or lets a state last one cycle too long. It covers a hold value of 0, which a design that does not clamp it would turn into a very long state. It also changes the hold value in mid-sequence, which a design that does not capture it would follow. It raises a stray request while busy, which a careless design would restart on. It keeps data valid during a parked sequence, which a leaky handshake would accept. Finally it checks the exact length of the wake-up mark, which an off-by-one counter gets wrong, and sends a wake while idle.

// File: rtl/esc_lane_tx.sv
module esc_lane_tx #(
  parameter int CNT_W    = 8,
  parameter int WAKE_CYC = 125000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] hold_cycles,
  input  logic             req,
  input  logic             req_ulp,
  input  logic [7:0]       req_cmd,
  input  logic             tx_valid,
  input  logic [7:0]       tx_data,
  output logic             tx_ready,
  input  logic             wake,
  output logic             lp_p,
  output logic             lp_n,
  output logic             busy
);
  localparam int WK_W = $clog2(WAKE_CYC + 1);
  localparam int TW   = (WK_W > CNT_W) ? WK_W : CNT_W;

  typedef enum logic [3:0] {
    S_IDLE, S_E1, S_E2, S_E3, S_E4, S_MARK, S_SPACE, S_ULP, S_WAKE, S_EXIT
  } st_t;

  st_t              state;
  logic [TW-1:0]    cnt;
  logic [CNT_W-1:0] hold_q;
  logic [7:0]       sh;
  logic [2:0]       bit_i;
  logic             ulp_q;
  logic [CNT_W-1:0] hold_eff;
  logic [1:0]       lvl;

  assign hold_eff = (hold_cycles == '0) ? CNT_W'(1) : hold_cycles;
  assign busy     = (state != S_IDLE);
  assign tx_ready = (state == S_SPACE) && (cnt == '0) && (bit_i == 3'd7) && !ulp_q && tx_valid;
  assign lp_p     = lvl[1];
  assign lp_n     = lvl[0];

  always_comb begin
    case (state)
      S_IDLE:  lvl = 2'b11;
      S_E1:    lvl = 2'b10;
      S_E3:    lvl = 2'b01;
      S_MARK:  lvl = sh[0] ? 2'b10 : 2'b01;
      S_WAKE:  lvl = 2'b10;
      S_EXIT:  lvl = 2'b10;
      default: lvl = 2'b00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      hold_q <= CNT_W'(1);
      sh     <= '0;
      bit_i  <= '0;
      ulp_q  <= 1'b0;
    end else if (state == S_IDLE) begin
      if (req) begin
        state  <= S_E1;
        hold_q <= hold_eff;
        cnt    <= TW'(hold_eff - CNT_W'(1));
        ulp_q  <= req_ulp;
        sh     <= req_cmd;
        bit_i  <= '0;
      end
    end else if (state == S_ULP) begin
      if (wake) begin
        state <= S_WAKE;
        cnt   <= TW'(WAKE_CYC - 1);
      end
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end else begin
      cnt <= TW'(hold_q - CNT_W'(1));
      case (state)
        S_E1:   state <= S_E2;
        S_E2:   state <= S_E3;
        S_E3:   state <= S_E4;
        S_E4:   state <= S_MARK;
        S_MARK: state <= S_SPACE;
        S_SPACE: begin
          if (bit_i != 3'd7) begin
            sh    <= sh >> 1;
            bit_i <= bit_i + 3'd1;
            state <= S_MARK;
          end else if (ulp_q) begin
            state <= S_ULP;
          end else if (tx_valid) begin
            sh    <= tx_data;
            bit_i <= '0;
            state <= S_MARK;
          end else begin
            state <= S_EXIT;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/esc_lane_tx_chk.sv
module esc_lane_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic lp_p,
  input logic lp_n,
  input logic busy,
  input logic tx_ready
);
  // R8
  idle_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (lp_p && lp_n));
  // R2
  entry_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (lp_p && !lp_n));
  // R3
  mark0_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lp_p && lp_n && busy) |=> !(lp_p && !lp_n));
  // R3
  mark1_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_p && !lp_n) |=> !(!lp_p && lp_n));
  // R5
  stop_after_mark1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(lp_p && !lp_n));
  // R4
  ready_in_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (busy && !lp_p && !lp_n));
endmodule

bind esc_lane_tx esc_lane_tx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .lp_p(lp_p), .lp_n(lp_n), .busy(busy), .tx_ready(tx_ready)
);

// File: tb/esc_lane_tx_tb_top.sv
module esc_lane_tx_tb_top;
  localparam int CNT_W = 4;
  localparam int WK    = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CNT_W-1:0] hold_cycles = '0;
  logic req = 1'b0, req_ulp = 1'b0, tx_valid = 1'b0, wake = 1'b0;
  logic [7:0] req_cmd = '0, tx_data = '0;
  logic tx_ready, lp_p, lp_n, busy;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  esc_lane_tx #(.CNT_W(CNT_W), .WAKE_CYC(WK)) dut_i (
    .clk(clk), .rst_n(rst_n), .hold_cycles(hold_cycles), .req(req), .req_ulp(req_ulp),
    .req_cmd(req_cmd), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .wake(wake), .lp_p(lp_p), .lp_n(lp_n), .busy(busy)
  );

  // {cmd[15:8], ulp[7], nbytes[6:5], hold[4:1], stray_req[0]}
  localparam logic [15:0] VEC [6] = '{
    {8'hE1, 1'b0, 2'd0, 4'd1, 1'b0},
    {8'h1E, 1'b0, 2'd2, 4'd3, 1'b0},
    {8'h78, 1'b1, 2'd0, 4'd2, 1'b0},
    {8'hA5, 1'b0, 2'd3, 4'd0, 1'b0},
    {8'h3C, 1'b0, 2'd1, 4'd5, 1'b1},
    {8'h87, 1'b1, 2'd0, 4'd1, 1'b1}
  };

  logic [1:0] exp_lvl [128];
  int         exp_len [128];
  logic [1:0] obs_lvl [128];
  int         obs_len [128];
  int nexp, nobs;

  function automatic logic [7:0] dat(input int i, input logic [7:0] c);
    return 8'(8'h5A + i * 37) ^ c;
  endfunction

  task automatic check(input bit ok, input string rq, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, expv);
    end
  endtask

  task automatic push_exp(input logic [1:0] l, input int n);
    exp_lvl[nexp] = l; exp_len[nexp] = n; nexp++;
  endtask

  task automatic run_case(input logic [15:0] v);
    logic [7:0] cmd = v[15:8];
    bit ulp = v[7];
    int nb = int'(v[6:5]);
    int h = (v[4:1] == 0) ? 1 : int'(v[4:1]);
    bit stray = v[0];
    int w = 20 * h + 10;
    int idx = 0, c = 0, busy_bad = 0, rdy_bad = 0;
    logic [1:0] cur, lvl;
    int cl;
    logic [7:0] b;
    nexp = 0; nobs = 0;
    push_exp(2'b10, h); push_exp(2'b00, h); push_exp(2'b01, h); push_exp(2'b00, h);
    for (int k = 0; k <= nb; k++) begin
      b = (k == 0) ? cmd : dat(k - 1, cmd);
      for (int i = 0; i < 8; i++) begin
        push_exp(b[i] ? 2'b10 : 2'b01, h);
        push_exp(2'b00, h);
      end
    end
    if (ulp) begin
      exp_len[nexp-1] = h + 11;
      push_exp(2'b10, WK);
    end else push_exp(2'b10, h);

    @(negedge clk);
    req = 1'b1; req_cmd = cmd; req_ulp = ulp; hold_cycles = v[4:1];
    @(negedge clk);
    req = 1'b0;
    cur = {lp_p, lp_n}; cl = 0;
    while (c < 5000) begin
      lvl = {lp_p, lp_n};
      if (lvl == 2'b11) begin
        if (busy) busy_bad++;
        break;
      end
      if (!busy) busy_bad++;
      if (lvl == cur) cl++;
      else begin
        obs_lvl[nobs] = cur; obs_len[nobs] = cl; nobs++;
        cur = lvl; cl = 1;
      end
      if (stray && c == 3) begin
        req = 1'b1; req_cmd = ~cmd; req_ulp = ~ulp; hold_cycles = 4'd15;
      end else req = 1'b0;
      wake = (ulp && c == w);
      tx_valid = ulp ? 1'b1 : (idx < nb);
      tx_data = dat(idx, cmd);
      #1;
      if (tx_ready) begin
        if (ulp) rdy_bad++;
        idx++;
      end
      @(negedge clk);
      c++;
    end
    obs_lvl[nobs] = cur; obs_len[nobs] = cl; nobs++;
    req = 1'b0; wake = 1'b0; tx_valid = 1'b0;

    check(nobs == nexp, "R2/R3", "segment count", nobs, nexp);
    begin
      int bad = -1;
      for (int k = 0; k < nexp && k < nobs; k++)
        if (bad < 0 && (obs_lvl[k] != exp_lvl[k] || obs_len[k] != exp_len[k])) bad = k;
      if (bad >= 0)
        check(0, ulp ? "R3/R6/R7" : (stray ? "R9/R10" : "R3/R5"), "segment level*1000+length",
              int'(obs_lvl[bad]) * 1000 + obs_len[bad], int'(exp_lvl[bad]) * 1000 + exp_len[bad]);
      else check(1, "R3", "segments", 0, 0);
    end
    check(busy_bad == 0, "R8", "busy mismatches", busy_bad, 0);
    check(rdy_bad == 0, "R6", "ready while parked", rdy_bad, 0);
    check(idx == (ulp ? 0 : nb), "R4", "bytes taken", idx, ulp ? 0 : nb);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", checks + 1, fails);
    $finish;
  end

  initial begin
    tx_valid = 1'b1;
    repeat (3) @(negedge clk);
    check(lp_p && lp_n, "R1", "lines in reset", {lp_p, lp_n}, 3);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(lp_p && lp_n, "R1", "lines idle", {lp_p, lp_n}, 3);
    check(!busy, "R1", "busy idle", busy, 0);
    check(!tx_ready, "R1", "ready idle", tx_ready, 0);
    tx_valid = 1'b0;

    for (int v = 0; v < 6; v++) run_case(VEC[v]);

    // R7: wake while idle
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
    repeat (4) @(negedge clk);
    check(lp_p && lp_n && !busy, "R7", "idle after stray wake", {busy, lp_p, lp_n}, 3);

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule